// File: doc/BRIEF.md
# I2C Single-Byte Register Read Sequencer

This block runs one complete read of a single byte from a 7-bit addressed I2C target. It does not drive the bus wires itself. Instead it issues a sequence of commands to a bit-level engine and waits for that engine to answer each one. A requester raises a one-cycle request and uses a one-bit port select to choose which of two target devices is read. The block then walks through its phases and returns a 16-bit result.

The phases run in this order: start condition, address byte, one data byte read, a not-acknowledge on that final byte, and a stop condition. On success the upper byte of the result is zero and the lower byte holds the data. When the start, address or data phase reports an error, the block skips the remaining phases. It still issues a stop condition, and then returns a result whose upper byte identifies the phase that failed and whose lower byte carries the engine's error bits. Changing direction within a transaction would mean sending the address again with the other read/write bit. The block never does this: each transaction is read-only, so it sends the address exactly once.

Top module: `i2c_rdseq`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `done` and `cmd_valid` are 0 and `result` is 0x0000.
- R2: The address byte sent with the write-byte command equals the selected device address plus 1, so the read/write flag in bit 0 is 1 (read). Port 0 uses 0x76 (sent as 0x77) and port 1 uses 0x7A by default (sent as 0x7B).
- R3: A transaction without errors issues exactly these commands in this order, using the `cmd_op` codes start=1, write-byte=2, read-byte=3, send-not-acknowledge=4, stop=5: 1, 2, 3, 4, 5.
- R4: On success, `result` = {0x00, data byte returned by the read command}, and `done` is high for exactly one cycle.
- R5: A start command answered with nonzero `eng_err` e gives `result` = {0xFF, e}. The commands issued are 1, 5.
- R6: A write-byte (address) command answered with nonzero `eng_err` e gives `result` = {0xFE, e}. The commands issued are 1, 2, 5.
- R7: A read-byte command answered with nonzero `eng_err` e gives `result` = {0xFC, e}. The commands issued are 1, 2, 3, 5.
- R8: Every transaction ends with a stop command before `done`. Each command is a one-cycle `cmd_valid` pulse, and the next command is issued only after `eng_done` answers the previous one.
- R9: `busy` rises in the cycle after a request is accepted and falls in the same cycle that `done` rises. A request made while `busy` is high is ignored: it causes no second transaction, and neither its port nor anything else it carries has any effect.
- R10: Error bits returned for the not-acknowledge and stop commands are ignored and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a read transaction |
| req_port | input | 1 | Device select: 0 or 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Phase tag and error bits, or 0x00 and data |
| cmd_valid | output | 1 | One-cycle command strobe to the bit engine |
| cmd_op | output | 3 | Command code (1 start, 2 write, 3 read, 4 nack, 5 stop) |
| cmd_wdata | output | 8 | Byte to transmit with a write command |
| eng_done | input | 1 | Bit engine finished the current command |
| eng_err | input | 8 | Engine error bits; nonzero marks failure |
| eng_rdata | input | 8 | Byte received by a read command |

## Verification
The bench runs successful reads on both ports, with engine latencies from one to three cycles. These show that the address byte follows the port select and that response timing does not shift the result. Failures are injected separately in the start, address and data phases. Each failure must produce its own tag and its own shortened command list, so that a fault in phase decoding or in the forced stop shows up. Further runs cover data bytes 0x00 and 0xFF, error bits returned on the not-acknowledge and stop commands, and a second request raised mid-transaction. Together these separate data mixing from tag mixing, check that late-phase errors are really ignored, and show whether an extra request can restart the sequence or change the selected port.

// File: rtl/i2c_rdseq_pkg.sv
package i2c_rdseq_pkg;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_NACK  = 3'd4,
    OP_STOP  = 3'd5
  } op_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_ADDR,
    PH_READ,
    PH_NACK,
    PH_STOP
  } phase_t;

  localparam logic [BYTE_W-1:0] TAG_START = 8'hFF;
  localparam logic [BYTE_W-1:0] TAG_ADDR  = 8'hFE;
  localparam logic [BYTE_W-1:0] TAG_READ  = 8'hFC;
endpackage

// File: rtl/i2c_rdseq_fsm.sv
module i2c_rdseq_fsm
  import i2c_rdseq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV0_ADDR = 8'h76,
  parameter logic [BYTE_W-1:0] DEV1_ADDR = 8'h7A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_port,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_err,
  output logic              busy,
  output logic              cmd_valid,
  output op_t               cmd_op,
  output logic [BYTE_W-1:0] cmd_wdata,
  output logic              clr_code,
  output logic              set_err,
  output logic [BYTE_W-1:0] err_tag,
  output logic              set_data,
  output logic              publish
);
  localparam logic [BYTE_W-1:0] RD_BYTE0 = DEV0_ADDR + 8'd1;
  localparam logic [BYTE_W-1:0] RD_BYTE1 = DEV1_ADDR + 8'd1;

  phase_t phase, phase_nx;
  logic   issued;
  logic   sel_port;
  logic   accept;
  logic   failed;
  op_t    op_for_phase;

  assign accept = issued && !cmd_valid && eng_done;
  assign failed = (eng_err != '0);

  always_comb begin
    op_for_phase = OP_NONE;
    err_tag      = '0;
    phase_nx     = phase;
    case (phase)
      PH_START: begin
        op_for_phase = OP_START;
        err_tag      = TAG_START;
        phase_nx     = failed ? PH_STOP : PH_ADDR;
      end
      PH_ADDR: begin
        op_for_phase = OP_WRITE;
        err_tag      = TAG_ADDR;
        phase_nx     = failed ? PH_STOP : PH_READ;
      end
      PH_READ: begin
        op_for_phase = OP_READ;
        err_tag      = TAG_READ;
        phase_nx     = failed ? PH_STOP : PH_NACK;
      end
      PH_NACK: begin
        op_for_phase = OP_NACK;
        phase_nx     = PH_STOP;
      end
      PH_STOP: begin
        op_for_phase = OP_STOP;
        phase_nx     = PH_IDLE;
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  assign clr_code = (phase == PH_IDLE) && req_valid;
  assign set_err  = accept && failed &&
                    (phase == PH_START || phase == PH_ADDR || phase == PH_READ);
  assign set_data = accept && !failed && (phase == PH_READ);
  assign publish  = accept && (phase == PH_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      issued    <= 1'b0;
      busy      <= 1'b0;
      sel_port  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_wdata <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (phase == PH_IDLE) begin
        if (req_valid) begin
          sel_port <= req_port;
          busy     <= 1'b1;
          issued   <= 1'b0;
          phase    <= PH_START;
        end
      end else if (!issued) begin
        cmd_valid <= 1'b1;
        cmd_op    <= op_for_phase;
        cmd_wdata <= (phase == PH_ADDR) ? (sel_port ? RD_BYTE1 : RD_BYTE0) : '0;
        issued    <= 1'b1;
      end else if (accept) begin
        issued <= 1'b0;
        phase  <= phase_nx;
        if (phase == PH_STOP) busy <= 1'b0;
      end
    end
  end

  // R8: a command strobe never lasts more than one cycle
  assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R9: commands only go out inside a transaction
  assert_cmd_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);
  // R9: busy only rises after a request
  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  // R8: the transaction only ends out of the stop phase
  assert_stop_last_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(phase) == PH_STOP);
endmodule

// File: rtl/i2c_rdseq_result.sv
module i2c_rdseq_result
  import i2c_rdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_code,
  input  logic              set_err,
  input  logic [BYTE_W-1:0] err_tag,
  input  logic [BYTE_W-1:0] err_bits,
  input  logic              set_data,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              publish,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  logic [RES_W-1:0] code;

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= publish;
      if (clr_code)      code <= '0;
      else if (set_err)  code <= {err_tag, err_bits};
      else if (set_data) code <= {{BYTE_W{1'b0}}, rd_byte};
      if (publish) result <= code;
    end
  end

  // R4: completion is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: a published upper byte is zero or one of the three phase tags
  assert_tag_valid_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (result[RES_W-1:BYTE_W] == 8'h00 || result[RES_W-1:BYTE_W] == TAG_START ||
              result[RES_W-1:BYTE_W] == TAG_ADDR || result[RES_W-1:BYTE_W] == TAG_READ));
endmodule

// File: rtl/i2c_rdseq.sv
module i2c_rdseq
  import i2c_rdseq_pkg::*;
#(
  parameter logic [7:0] DEV0_ADDR = 8'h76,
  parameter logic [7:0] DEV1_ADDR = 8'h7A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_port,
  output logic        busy,
  output logic        done,
  output logic [15:0] result,
  output logic        cmd_valid,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_wdata,
  input  logic        eng_done,
  input  logic [7:0]  eng_err,
  input  logic [7:0]  eng_rdata
);
  op_t              op_q;
  logic             clr_code, set_err, set_data, publish;
  logic [BYTE_W-1:0] err_tag;

  i2c_rdseq_fsm #(.DEV0_ADDR(DEV0_ADDR), .DEV1_ADDR(DEV1_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .eng_done(eng_done), .eng_err(eng_err), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_op(op_q), .cmd_wdata(cmd_wdata),
    .clr_code(clr_code), .set_err(set_err), .err_tag(err_tag),
    .set_data(set_data), .publish(publish)
  );

  i2c_rdseq_result u_res (
    .clk(clk), .rst(rst), .clr_code(clr_code), .set_err(set_err),
    .err_tag(err_tag), .err_bits(eng_err), .set_data(set_data),
    .rd_byte(eng_rdata), .publish(publish), .done(done), .result(result)
  );

  assign cmd_op = op_q;

  // R9: busy is low when the completion pulse is shown
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/test_i2c_rdseq.sv
module test_i2c_rdseq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_port = 1'b0;
  logic        busy, done, cmd_valid;
  logic [15:0] result;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_wdata;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_err = 8'h00;
  logic [7:0]  eng_rdata = 8'h00;

  always #4 clk = ~clk;

  i2c_rdseq i_i2c_rdseq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .busy(busy), .done(done), .result(result), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .eng_done(eng_done),
    .eng_err(eng_err), .eng_rdata(eng_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  logic [15:0] exp_q[$];

  // bit engine model configuration
  int         cfg_fail = 0;     // 0 none, 1 start, 2 address, 3 read
  logic [7:0] cfg_err  = 8'h00;
  logic [7:0] cfg_aux  = 8'h00; // error bits returned on nack and stop
  logic [7:0] cfg_data = 8'h00;
  int         cfg_lat  = 1;
  logic [2:0] op_log[64];
  logic [7:0] addr_seen = 8'h00;
  int         n_ops = 0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit engine
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [2:0] op;
        logic [7:0] e;
        op = cmd_op;
        if (n_ops < 64) op_log[n_ops] = op;
        n_ops++;
        if (op == 3'd2) addr_seen = cmd_wdata;
        e = 8'h00;
        if ((op == 3'd1 && cfg_fail == 1) || (op == 3'd2 && cfg_fail == 2) ||
            (op == 3'd3 && cfg_fail == 3)) e = cfg_err;
        if (op == 3'd4 || op == 3'd5) e = cfg_aux;
        repeat (cfg_lat - 1) @(negedge clk);
        @(negedge clk);
        eng_done  = 1'b1;
        eng_err   = e;
        eng_rdata = (op == 3'd3) ? cfg_data : 8'h5E;
        @(negedge clk);
        eng_done  = 1'b0;
        eng_err   = 8'h00;
        eng_rdata = 8'h00;
      end
    end
  end

  // monitor: pops expected results as completions appear
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", result, 16'hxxxx);
        else begin
          logic [15:0] ex;
          ex = exp_q.pop_front();
          chk(result == ex, "R4/R5/R6/R7 result", result, ex);
          chk(busy == 1'b0, "R9 busy low at done", {15'd0, busy}, 16'd0);
        end
      end
    end
  end

  task automatic run_txn(input bit port, input int fail, input logic [7:0] err,
                         input logic [7:0] data, input int lat, input logic [7:0] aux,
                         input bit poke, input string tag);
    int base, n_exp, prev_done;
    logic [2:0] eops[6];
    logic [15:0] ex;
    cfg_fail = fail; cfg_err = err; cfg_data = data; cfg_lat = lat; cfg_aux = aux;
    case (fail)
      1: begin ex = {8'hFF, err}; eops[0]=1; eops[1]=5; n_exp = 2; end
      2: begin ex = {8'hFE, err}; eops[0]=1; eops[1]=2; eops[2]=5; n_exp = 3; end
      3: begin ex = {8'hFC, err}; eops[0]=1; eops[1]=2; eops[2]=3; eops[3]=5; n_exp = 4; end
      default: begin ex = {8'h00, data}; eops[0]=1; eops[1]=2; eops[2]=3; eops[3]=4; eops[4]=5; n_exp = 5; end
    endcase
    exp_q.push_back(ex);
    base = n_ops;
    prev_done = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_port = port;
    @(negedge clk);
    req_valid = 1'b0; req_port = 1'b0;
    chk(busy == 1'b1, {tag, " R9 busy after accept"}, {15'd0, busy}, 16'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_port = ~port;
      @(negedge clk);
      req_valid = 1'b0; req_port = 1'b0;
    end
    while (done_cnt == prev_done) @(negedge clk);
    chk(n_ops - base == n_exp, {tag, " R8 command count"}, 16'(n_ops - base), 16'(n_exp));
    for (int i = 0; i < n_exp; i++)
      if (i < n_ops - base)
        chk(op_log[base + i] == eops[i], {tag, " R3 command order"},
            {13'd0, op_log[base + i]}, {13'd0, eops[i]});
    if (fail != 1)
      chk(addr_seen == (port ? 8'h7B : 8'h77), {tag, " R2 address byte"},
          {8'd0, addr_seen}, {8'd0, (port ? 8'h7B : 8'h77)});
    repeat (12) @(negedge clk);
    chk(done_cnt == prev_done + 1 && n_ops - base == n_exp, {tag, " R9 no extra transaction"},
        16'(done_cnt - prev_done), 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid && result == 16'h0, "R1 reset outputs", result, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !cmd_valid && result == 16'h0, "R1 after reset", result, 16'h0);
    run_txn(1'b0, 0, 8'h00, 8'hA5, 1, 8'h00, 1'b0, "R3 R4 port0");
    run_txn(1'b1, 0, 8'h00, 8'h3C, 3, 8'h00, 1'b0, "R2 port1 slow");
    run_txn(1'b0, 1, 8'h01, 8'h11, 2, 8'h00, 1'b0, "R5 start fail");
    run_txn(1'b1, 2, 8'h02, 8'h22, 1, 8'h00, 1'b0, "R6 addr nack");
    run_txn(1'b0, 3, 8'h04, 8'h33, 2, 8'h00, 1'b0, "R7 read fail");
    run_txn(1'b1, 0, 8'h00, 8'h5A, 1, 8'h80, 1'b0, "R10 late errors");
    run_txn(1'b0, 0, 8'h00, 8'h81, 2, 8'h00, 1'b1, "R9 ignored request");
    run_txn(1'b0, 0, 8'h00, 8'h00, 1, 8'h00, 1'b0, "R4 data zero");
    run_txn(1'b1, 0, 8'h00, 8'hFF, 1, 8'h00, 1'b0, "R4 data ones");
    run_txn(1'b0, 2, 8'hFF, 8'h00, 3, 8'h00, 1'b0, "R6 all error bits");
    chk(exp_q.size() == 0, "R4 all results seen", 16'(exp_q.size()), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule